// File: doc/BRIEF.md
# Capture/Reload Timer with Up/Down Count

This block is a 16-bit timer with a 16-bit capture/reload register beside it. One counter serves four uses, picked by a two-bit mode input. It can take a snapshot of the running count when an external trigger falls. It can reload automatically, counting up or down as a direction pin selects. It can emit a periodic tick for a serial baud clock. It can drive a square-wave clock output. A run input starts and stops counting. Counting steps on prescaled ticks. In the capture and reload uses the divider is 12 or 4, chosen by an input. In the baud and clock-output uses the divider is always 2, whatever that input says.

The count and the capture/reload register are loaded through a single-word write port. Two sticky flags record overflow events and trigger captures. One input clears both flags. Mode encoding is 0 capture, 1 reload, 2 baud, 3 clock-out. A falling trigger edge is seen one clock after the high level was sampled. Trigger edges act only in capture mode.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset the count, the capture/reload register, both flags, the baud tick and the clock output are all 0.
- R2: With run high, the count steps once every 12 clocks when fast_tb_i is 0, or every 4 clocks when it is 1, in modes 0 and 1. The first step comes on the divider-th rising edge after run rises. With run low the count holds.
- R3: In mode 0 the count always counts up. It wraps from FFFFh to 0000h and the capture/reload register is not used as a reload value.
- R4: In mode 0, a 1-to-0 change on trig_i, sampled on consecutive edges, copies the pre-edge count into the capture register and sets ext_flag_o. The count keeps running. In other modes trigger edges change neither.
- R5: In mode 1 with dir_up_i high, a step from FFFFh loads the capture/reload value.
- R6: In mode 1 with dir_up_i low, a step taken while the count equals the reload value loads FFFFh. Any other step decrements. dir_up_i is sampled at every step.
- R7: In modes 2 and 3 the count steps every 2 clocks regardless of fast_tb_i, and a step from FFFFh loads the reload value.
- R8: In mode 2 baud_tick_o is high for exactly the clock after each overflow edge, and low otherwise.
- R9: In mode 3 clk_out_o toggles on each overflow edge and is otherwise steady.
- R10: wr_en_i with wr_sel_i=0 loads the count, and with wr_sel_i=1 loads the capture/reload register. A write wins over a step or a capture on the same edge, and a count write suppresses that edge's overflow.
- R11: Every overflow (FFFFh wrap or reload, or the down-count reload) sets ovf_flag_o. clr_flags_i clears both flags, but a set on the same edge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counting enable |
| fast_tb_i | input | 1 | Time base select: 0 = divide by 12, 1 = divide by 4 |
| mode_i | input | 2 | 0 capture, 1 reload, 2 baud, 3 clock-out |
| dir_up_i | input | 1 | Count direction in reload mode, 1 = up |
| trig_i | input | 1 | External capture trigger |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | Write target: 0 count, 1 capture/reload |
| wr_data_i | input | 16 | Write data |
| clr_flags_i | input | 1 | Clear both sticky flags |
| count_o | output | 16 | Current count |
| cap_o | output | 16 | Capture/reload register |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ext_flag_o | output | 1 | Sticky trigger-capture flag |
| baud_tick_o | output | 1 | One-clock baud pulse |
| clk_out_o | output | 1 | Square-wave clock output |

## Verification
All results are registered and show up right after the edge that causes them. A step, a reload, a write, a capture, a flag change, the baud pulse and a clock-output toggle all land on one edge. The step edge is the divider-th edge after run rises, counted from a cleared prescaler. A trigger fall acts on the first edge at which the low level is sampled after a high one. The bench drives every input 1 ns after a rising edge. It updates a per-edge model from the requirements and compares all outputs 1 ns after every edge. Each step, reload and pulse is therefore checked in exactly the cycle it is due.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_CAPT   = 2'd0,
    MODE_RELOAD = 2'd1,
    MODE_BAUD   = 2'd2,
    MODE_CLKO   = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV_SLOW = 12,
  parameter int unsigned DIV_FAST = 4,
  parameter int unsigned DIV_GEN  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fast_i,
  input  logic gen_i,
  output logic tick_o
);
  localparam int unsigned DMAX0 = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int unsigned DMAX  = (DMAX0 > DIV_GEN) ? DMAX0 : DIV_GEN;
  localparam int unsigned PW    = $clog2(DMAX + 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;

  // generator uses force the short divider
  always_comb begin
    if (gen_i)       lim = PW'(DIV_GEN - 1);
    else if (fast_i) lim = PW'(DIV_FAST - 1);
    else             lim = PW'(DIV_SLOW - 1);
  end

  assign tick_o = run_i && (pre_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (!run_i || tick_o)  pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  tmr_mode_e    mode_i,
  input  logic         dir_up_i,
  input  logic         wr_cnt_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] count_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic at_top, at_floor, going_down;

  assign at_top     = &cnt_q;
  assign at_floor   = (cnt_q == reload_i);
  assign going_down = (mode_i == MODE_RELOAD) && !dir_up_i;

  always_comb begin
    cnt_d = cnt_q;
    ovf_o = 1'b0;
    if (wr_cnt_i) begin
      cnt_d = wr_data_i;
    end else if (tick_i) begin
      if (going_down) begin
        if (at_floor) begin
          cnt_d = '1;
          ovf_o = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else if (at_top) begin
        ovf_o = 1'b1;
        cnt_d = (mode_i == MODE_CAPT) ? '0 : reload_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         arm_i,
  input  logic         trig_i,
  input  logic         wr_cap_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] count_i,
  output logic [W-1:0] cap_o,
  output logic         fall_o
);
  logic trig_q;
  logic [W-1:0] cap_q;

  assign fall_o = arm_i && trig_q && !trig_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      trig_q <= trig_i;
      if (wr_cap_i)    cap_q <= wr_data_i;
      else if (fall_o) cap_q <= count_i;
    end
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/tmr_event_out.sv
module tmr_event_out
  import tmr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  tmr_mode_e mode_i,
  input  logic      ovf_i,
  input  logic      fall_i,
  input  logic      clr_i,
  output logic      ovf_flag_o,
  output logic      ext_flag_o,
  output logic      baud_tick_o,
  output logic      clk_out_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_flag_o  <= 1'b0;
      ext_flag_o  <= 1'b0;
      baud_tick_o <= 1'b0;
      clk_out_o   <= 1'b0;
    end else begin
      // set beats clear
      if (ovf_i)      ovf_flag_o <= 1'b1;
      else if (clr_i) ovf_flag_o <= 1'b0;
      if (fall_i)     ext_flag_o <= 1'b1;
      else if (clr_i) ext_flag_o <= 1'b0;
      baud_tick_o <= ovf_i && (mode_i == MODE_BAUD);
      if (ovf_i && (mode_i == MODE_CLKO)) clk_out_o <= !clk_out_o;
    end
  end
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DIV_SLOW = 12,
  parameter int unsigned DIV_FAST = 4,
  parameter int unsigned DIV_GEN  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             fast_tb_i,
  input  logic [1:0]       mode_i,
  input  logic             dir_up_i,
  input  logic             trig_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             clr_flags_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             ovf_flag_o,
  output logic             ext_flag_o,
  output logic             baud_tick_o,
  output logic             clk_out_o
);
  tmr_mode_e mode;
  logic tick, ovf_evt, fall_evt, gen_use;

  assign mode    = tmr_mode_e'(mode_i);
  assign gen_use = (mode == MODE_BAUD) || (mode == MODE_CLKO);

  tmr_prescaler #(
    .DIV_SLOW(DIV_SLOW),
    .DIV_FAST(DIV_FAST),
    .DIV_GEN (DIV_GEN)
  ) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_i),
    .fast_i(fast_tb_i),
    .gen_i (gen_use),
    .tick_o(tick)
  );

  tmr_count_core #(.W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .mode_i   (mode),
    .dir_up_i (dir_up_i),
    .wr_cnt_i (wr_en_i && !wr_sel_i),
    .wr_data_i(wr_data_i),
    .reload_i (cap_o),
    .count_o  (count_o),
    .ovf_o    (ovf_evt)
  );

  tmr_capture #(.W(CNT_W)) u_capt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (mode == MODE_CAPT),
    .trig_i   (trig_i),
    .wr_cap_i (wr_en_i && wr_sel_i),
    .wr_data_i(wr_data_i),
    .count_i  (count_o),
    .cap_o    (cap_o),
    .fall_o   (fall_evt)
  );

  tmr_event_out u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .ovf_i      (ovf_evt),
    .fall_i     (fall_evt),
    .clr_i      (clr_flags_i),
    .ovf_flag_o (ovf_flag_o),
    .ext_flag_o (ext_flag_o),
    .baud_tick_o(baud_tick_o),
    .clk_out_o  (clk_out_o)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         run_i,
  input logic [1:0]   mode_i,
  input logic         dir_up_i,
  input logic         trig_i,
  input logic         wr_en_i,
  input logic         tick_i,
  input logic         ovf_evt_i,
  input logic [W-1:0] count_i,
  input logic [W-1:0] cap_i,
  input logic         ovf_flag_i,
  input logic         ext_flag_i,
  input logic         baud_tick_i,
  input logic         clk_out_i
);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_en_i) |=> $stable(count_i));

  assert_wrap_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && tick_i && (&count_i) && !wr_en_i) |=> (count_i == '0));

  assert_ext_flag_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_flag_i) |-> ($past(mode_i) == 2'd0 && !$past(trig_i) && $past(trig_i, 2)));

  assert_up_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && dir_up_i && tick_i && (&count_i) && !wr_en_i)
      |=> (count_i == $past(cap_i)));

  assert_down_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && !dir_up_i && tick_i && count_i == cap_i && !wr_en_i)
      |=> (&count_i));

  assert_baud_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_tick_i |-> ($past(mode_i) == 2'd2 && $past(ovf_evt_i)));

  assert_baud_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_tick_i |=> !baud_tick_i);

  assert_clk_toggle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clk_out_i) |-> ($past(mode_i) == 2'd3 && $past(ovf_evt_i)));

  assert_ovf_flag_src_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_flag_i) |-> $past(ovf_evt_i));
endmodule

bind cap_reload_timer tmr_checker #(.W(CNT_W)) u_tmr_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .mode_i     (mode_i),
  .dir_up_i   (dir_up_i),
  .trig_i     (trig_i),
  .wr_en_i    (wr_en_i),
  .tick_i     (tick),
  .ovf_evt_i  (ovf_evt),
  .count_i    (count_o),
  .cap_i      (cap_o),
  .ovf_flag_i (ovf_flag_o),
  .ext_flag_i (ext_flag_o),
  .baud_tick_i(baud_tick_o),
  .clk_out_i  (clk_out_o)
);

// File: tb/cap_reload_timer_tb_top.sv
module cap_reload_timer_tb_top;
  localparam logic [1:0] M_CAPT = 2'd0, M_REL = 2'd1, M_BAUD = 2'd2, M_CLKO = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, fast = 0, dir_up = 0, trig = 0, wr_en = 0, wr_sel = 0, clr = 0;
  logic [1:0] mode = M_CAPT;
  logic [15:0] wr_data = '0;
  logic [15:0] count, cap;
  logic ovf_flag, ext_flag, baud_tick, clk_out;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model state
  logic [15:0] m_cnt = '0, m_cap = '0;
  logic m_ovf = 0, m_ext = 0, m_clk = 0, m_baud = 0, m_trig_q = 0;

  always #10 clk = ~clk;

  cap_reload_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .fast_tb_i(fast), .mode_i(mode),
    .dir_up_i(dir_up), .trig_i(trig), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .clr_flags_i(clr), .count_o(count), .cap_o(cap),
    .ovf_flag_o(ovf_flag), .ext_flag_o(ext_flag), .baud_tick_o(baud_tick),
    .clk_out_o(clk_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int div_of(input logic [1:0] md, input logic f);
    if (md == M_BAUD || md == M_CLKO) return 2;
    return f ? 4 : 12;
  endfunction

  // one rising edge of the requirement model, using the inputs currently driven
  task automatic model_edge(input bit tk);
    logic fall, ov;
    logic [15:0] nc, ncap;
    fall = m_trig_q && !trig && (mode == M_CAPT);
    ov = 0;
    nc = m_cnt;
    if (wr_en && !wr_sel) nc = wr_data;
    else if (tk) begin
      if (mode == M_REL && !dir_up) begin
        if (m_cnt == m_cap) begin nc = 16'hFFFF; ov = 1; end
        else nc = m_cnt - 16'd1;
      end else if (m_cnt == 16'hFFFF) begin
        ov = 1;
        nc = (mode == M_CAPT) ? 16'h0000 : m_cap;
      end else nc = m_cnt + 16'd1;
    end
    ncap = (wr_en && wr_sel) ? wr_data : (fall ? m_cnt : m_cap);
    m_ovf = ov ? 1'b1 : (clr ? 1'b0 : m_ovf);
    m_ext = fall ? 1'b1 : (clr ? 1'b0 : m_ext);
    if (ov && mode == M_CLKO) m_clk = !m_clk;
    m_baud = ov && (mode == M_BAUD);
    m_cnt = nc;
    m_cap = ncap;
    m_trig_q = trig;
  endtask

  task automatic check_all(input string cnt_tag, input string cap_tag);
    chk(cnt_tag, {16'h0, count}, {16'h0, m_cnt});
    chk(cap_tag, {16'h0, cap}, {16'h0, m_cap});
    chk("R11 ovf_flag", {31'h0, ovf_flag}, {31'h0, m_ovf});
    chk("R4 ext_flag", {31'h0, ext_flag}, {31'h0, m_ext});
    chk("R8 baud_tick", {31'h0, baud_tick}, {31'h0, m_baud});
    chk("R9 clk_out", {31'h0, clk_out}, {31'h0, m_clk});
  endtask

  task automatic set_reg(input logic sel, input logic [15:0] val);
    run = 0; wr_en = 1; wr_sel = sel; wr_data = val;
    @(posedge clk); #1;
    model_edge(0);
    wr_en = 0;
  endtask

  // trig pattern: 0 low, 1 toggle every 7 cycles; dir pattern: 0 down, 1 up, 2 alternate
  task automatic run_seq(input logic [1:0] md, input logic f, input int dirp, input int trigp,
                         input int k, input int wr_it, input logic sel, input logic [15:0] val,
                         input int clr_it, input string cnt_tag, input string cap_tag);
    int dv;
    mode = md; fast = f;
    dv = div_of(md, f);
    for (int i = 0; i < k; i++) begin
      run = 1;
      trig = (trigp == 1) ? logic'((i / 7) % 2) : 1'b0;
      dir_up = (dirp == 2) ? logic'((i / 9) % 2) : logic'(dirp);
      wr_en = (i == wr_it); wr_sel = sel; wr_data = val;
      clr = (i == clr_it);
      @(posedge clk); #1;
      model_edge(((i + 1) % dv) == 0);
      check_all(cnt_tag, cap_tag);
    end
    run = 0; trig = 0; wr_en = 0; clr = 0;
    @(posedge clk); #1;
    model_edge(0);
    check_all(cnt_tag, cap_tag);
    // run low holds the count
    repeat (3) @(posedge clk);
    #1;
    model_edge(0);
    chk("R2 hold", {16'h0, count}, {16'h0, m_cnt});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 count", {16'h0, count}, 32'h0);
    chk("R1 cap", {16'h0, cap}, 32'h0);
    chk("R1 ovf_flag", {31'h0, ovf_flag}, 32'h0);
    chk("R1 ext_flag", {31'h0, ext_flag}, 32'h0);
    chk("R1 baud_tick", {31'h0, baud_tick}, 32'h0);
    chk("R1 clk_out", {31'h0, clk_out}, 32'h0);
    rst_n = 1;
    @(posedge clk); #1;
    model_edge(0);

    // R3/R4: capture mode, slow base, wrap and trigger captures
    set_reg(0, 16'hFFF0);
    run_seq(M_CAPT, 0, 1, 1, 250, -1, 0, 0, -1, "R3 count", "R4 cap");
    // R2: fast base
    set_reg(0, 16'hFFF8);
    run_seq(M_CAPT, 1, 0, 1, 60, -1, 0, 0, 5, "R2 count", "R4 cap");
    // R5: reload up, trigger ignored
    set_reg(1, 16'hFFF0);
    set_reg(0, 16'hFFFA);
    run_seq(M_REL, 1, 1, 1, 120, -1, 0, 0, -1, "R5 count", "R4 cap");
    run_seq(M_REL, 0, 1, 0, 150, -1, 0, 0, 3, "R5 count", "R4 cap");
    // R6: reload down
    set_reg(1, 16'h0010);
    set_reg(0, 16'h0014);
    run_seq(M_REL, 1, 0, 1, 100, -1, 0, 0, -1, "R6 count", "R4 cap");
    set_reg(1, 16'h0005);
    set_reg(0, 16'h0002);
    run_seq(M_REL, 1, 0, 0, 60, -1, 0, 0, -1, "R6 count", "R4 cap");
    set_reg(1, 16'hFFF8);
    set_reg(0, 16'hFFFA);
    run_seq(M_REL, 1, 2, 0, 200, -1, 0, 0, -1, "R6 count", "R4 cap");
    // R7/R8: baud, divider 2 regardless of fast_tb_i
    set_reg(1, 16'hFFFC);
    set_reg(0, 16'hFFFC);
    run_seq(M_BAUD, 0, 1, 1, 60, -1, 0, 0, -1, "R7 count", "R4 cap");
    run_seq(M_BAUD, 1, 0, 0, 40, -1, 0, 0, -1, "R7 count", "R4 cap");
    // R7/R9: clock-out
    set_reg(1, 16'hFFFE);
    set_reg(0, 16'hFFFE);
    run_seq(M_CLKO, 0, 1, 0, 60, -1, 0, 0, -1, "R7 count", "R4 cap");
    set_reg(1, 16'hFFFF);
    run_seq(M_CLKO, 1, 0, 1, 30, -1, 0, 0, -1, "R9 count", "R4 cap");
    // R10: count write on a step edge, cap write on a trigger edge
    set_reg(0, 16'hFFFD);
    run_seq(M_CAPT, 1, 1, 0, 20, 3, 0, 16'h1234, -1, "R10 count", "R4 cap");
    run_seq(M_CAPT, 1, 1, 1, 30, 14, 1, 16'hABCD, -1, "R10 count", "R10 cap");
    // R11: clear on an overflow edge loses, clear elsewhere wins
    set_reg(0, 16'hFFFE);
    run_seq(M_CAPT, 1, 1, 1, 20, -1, 0, 0, 7, "R11 count", "R4 cap");
    run_seq(M_CAPT, 1, 1, 0, 6, -1, 0, 0, 2, "R11 count", "R4 cap");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule